// File: doc/BRIEF.md
# Head Stepper Phase and Drive Control Port

This block is the drive-control output port of a disk controller. Software writes one byte to it. The block keeps a copy of that byte, with one bit always cleared. It watches the two lowest bits, which hold the current phase of the head stepper motor. When a write moves the phase one position forward or back, modulo 4, the block emits a single-cycle pulse on a step-inward or step-outward output. A write that leaves the phase where it was, or jumps it to the opposite phase, produces no pulse. Bit 3 of the stored byte drives an activity LED. A one-cycle LED event marks each write that changes that bit.

On read, the block returns the stored byte combined with two live inputs. The top bit reports the sync detector, low-active. The write-protect input is ORed into its bit position. Tracking the head position is left to whatever consumes the step pulses.

The pulse logic is a three-state machine. `ST_IDLE` means no pulse. `ST_STEP_IN` means the step-inward pulse is high. `ST_STEP_OUT` means the step-outward pulse is high. Every edge picks the next state from the current write:
- A write whose old phase equals the new phase minus 1 goes to `ST_STEP_IN`.
- A write whose old phase equals the new phase plus 1 goes to `ST_STEP_OUT`.
- Any other cycle, with or without a write, goes to `ST_IDLE`.

No state stays for more than one cycle unless another qualifying write arrives.

Top module: `drvport`

## Requirements
- R1: While reset is held and after it is released, with no write, the stored port is 0. `step_in`, `step_out`, `led_on` and `led_evt` are all 0.
- R2: A write stores `wr_data` with bit 4 forced to 0. The stored value appears on `rd_data` from the cycle after the write strobe, in bits 6..5 and 3..0.
- R3: When the old phase (stored bits 1..0) equals the new phase (`wr_data[1:0]`) plus 1 modulo 4, `step_out` is 1 for the one cycle after the write strobe.
- R4: When the old phase equals the new phase minus 1 modulo 4, `step_in` is 1 for the one cycle after the write strobe.
- R5: A write whose new phase equals the old phase, or differs from it by 2, produces no pulse on `step_in` or `step_out`.
- R6: `step_in` and `step_out` are never 1 together. Neither is 1 in a cycle that does not follow a write strobe.
- R7: `led_on` equals stored bit 3. It changes in the cycle after the write strobe.
- R8: `led_evt` is 1 for the one cycle after a write that changes stored bit 3. Otherwise it is 0.
- R9: `rd_data[7]` is 0 while `sync_det` is 1 and 1 while it is 0. `rd_data[4]` equals `wprot`. Both follow their inputs in the same cycle.
- R10: A cycle without a write strobe leaves the stored port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the port register |
| wr_data | input | 8 | Byte to write |
| sync_det | input | 1 | Sync mark detected (1 = found) |
| wprot | input | 1 | Write-protect sense, ORed into read bit 4 |
| rd_data | output | 8 | Composed read value |
| step_in | output | 1 | One-cycle step-inward pulse |
| step_out | output | 1 | One-cycle step-outward pulse |
| led_on | output | 1 | Activity LED level (stored bit 3) |
| led_evt | output | 1 | One-cycle pulse when the LED bit changes |

## Verification
Four results follow a write strobe by exactly one clock:
- the stored port value,
- the step pulses,
- `led_on`,
- `led_evt`.

The read bits driven by `sync_det` and `wprot` follow their inputs in the same cycle. The bench therefore drives each stimulus at a falling edge. It computes the expected values from the phase and bit-3 state its model held before that write. It samples all outputs shortly after the next rising edge, so every check sees exactly one register stage. Idle cycles between writes confirm that the pulses last one cycle and that the port holds its value.

// File: rtl/drvport_pkg.sv
package drvport_pkg;
    localparam int PHASE_W  = 2;
    localparam int LED_BIT  = 3;
    localparam int CLR_BIT  = 4;
    localparam int WP_BIT   = 4;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_IN   = 2'd1,
        DIR_OUT  = 2'd2
    } step_dir_t;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_STEP_IN  = 2'd1,
        ST_STEP_OUT = 2'd2
    } step_state_t;
endpackage

// File: rtl/drvport_phase_cmp.sv
module drvport_phase_cmp
    import drvport_pkg::*;
(
    input  logic [PHASE_W-1:0] old_phase,
    input  logic [PHASE_W-1:0] new_phase,
    output step_dir_t          dir
);
    logic [PHASE_W-1:0] up_one;
    logic [PHASE_W-1:0] down_one;

    always_comb begin
        up_one   = new_phase + PHASE_W'(1);
        down_one = new_phase - PHASE_W'(1);
        if (old_phase == up_one) begin
            dir = DIR_OUT;
        end else if (old_phase == down_one) begin
            dir = DIR_IN;
        end else begin
            dir = DIR_NONE;
        end
    end
endmodule

// File: rtl/drvport_step_fsm.sv
module drvport_step_fsm
    import drvport_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PHASE_W-1:0] old_phase,
    input  logic [PHASE_W-1:0] new_phase,
    input  step_dir_t          dir,
    output logic               step_in,
    output logic               step_out
);
    step_state_t state_q;
    step_state_t state_d;

    always_comb begin
        state_d = ST_IDLE;
        if (wr_en) begin
            unique case (dir)
                DIR_IN:   state_d = ST_STEP_IN;
                DIR_OUT:  state_d = ST_STEP_OUT;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        step_in  = 1'b0;
        step_out = 1'b0;
        unique case (state_q)
            ST_STEP_IN:  step_in  = 1'b1;
            ST_STEP_OUT: step_out = 1'b1;
            default: begin
                step_in  = 1'b0;
                step_out = 1'b0;
            end
        endcase
    end

    // R3: one-behind phase yields an outward step
    a_r3_step_out: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && old_phase == new_phase + PHASE_W'(1)) |=> step_out);

    // R4: one-ahead phase yields an inward step
    a_r4_step_in: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && old_phase == new_phase - PHASE_W'(1)) |=> step_in);

    // R5: same or opposite phase yields nothing
    a_r5_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (old_phase == new_phase || old_phase == (new_phase ^ PHASE_W'(2))))
        |=> (!step_in && !step_out));

    // R6: no pulse without a preceding write, and never both
    a_r6_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!step_in && !step_out));
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_in && step_out));
endmodule

// File: rtl/drvport_read_mux.sv
module drvport_read_mux
    import drvport_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic [PORT_W-1:0] port_val,
    input  logic              sync_det,
    input  logic              wprot,
    output logic [PORT_W-1:0] rd_data
);
    localparam int SYNC_BIT = PORT_W - 1;

    always_comb begin
        rd_data           = port_val;
        rd_data[WP_BIT]   = port_val[WP_BIT] | wprot;
        rd_data[SYNC_BIT] = ~sync_det;
    end
endmodule

// File: rtl/drvport.sv
module drvport
    import drvport_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_data,
    input  logic              sync_det,
    input  logic              wprot,
    output logic [PORT_W-1:0] rd_data,
    output logic              step_in,
    output logic              step_out,
    output logic              led_on,
    output logic              led_evt
);
    logic [PORT_W-1:0] port_q;
    logic [PORT_W-1:0] port_d;
    logic              led_evt_q;
    step_dir_t         dir;

    always_comb begin
        port_d          = wr_data;
        port_d[CLR_BIT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q    <= '0;
            led_evt_q <= 1'b0;
        end else begin
            led_evt_q <= wr_en && (wr_data[LED_BIT] != port_q[LED_BIT]);
            if (wr_en) begin
                port_q <= port_d;
            end
        end
    end

    drvport_phase_cmp u_cmp (
        .old_phase (port_q[PHASE_W-1:0]),
        .new_phase (wr_data[PHASE_W-1:0]),
        .dir       (dir)
    );

    drvport_step_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .old_phase (port_q[PHASE_W-1:0]),
        .new_phase (wr_data[PHASE_W-1:0]),
        .dir       (dir),
        .step_in   (step_in),
        .step_out  (step_out)
    );

    drvport_read_mux #(.PORT_W(PORT_W)) u_rd (
        .port_val (port_q),
        .sync_det (sync_det),
        .wprot    (wprot),
        .rd_data  (rd_data)
    );

    assign led_on  = port_q[LED_BIT];
    assign led_evt = led_evt_q;

    // R10: idle cycles hold the port
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data[3:0]));

    // R8: LED event only after a write that flips bit 3
    a_r8_led_evt: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_data[LED_BIT] == led_on) |=> !led_evt);

    // R7: LED follows the written bit
    a_r7_led_level: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (led_on == $past(wr_data[LED_BIT])));

    // R2: cleared bit never reads back set unless write-protect is high
    a_r2_clr_bit: assert property (@(posedge clk) disable iff (!rst_n)
        !wprot |-> !rd_data[WP_BIT]);
endmodule

// File: tb/drvport_tb_top.sv
module drvport_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       sync_det = 1'b0;
    logic       wprot = 1'b0;
    logic [7:0] rd_data;
    logic       step_in, step_out, led_on, led_evt;

    int errors = 0;
    int checks = 0;
    logic [7:0] m_port = 8'h00;
    int m_track = 0;
    int d_track = 0;

    always #4 clk = ~clk;

    drvport dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .sync_det(sync_det), .wprot(wprot), .rd_data(rd_data),
        .step_in(step_in), .step_out(step_out), .led_on(led_on), .led_evt(led_evt)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] f_read(input logic [7:0] p, input logic s, input logic w);
        logic [7:0] r;
        r = p;
        r[4] = p[4] | w;
        r[7] = ~s;
        return r;
    endfunction

    // returns 1 = inward, 2 = outward, 0 = none
    function automatic int f_dir(input logic [1:0] oldp, input logic [1:0] newp);
        if (oldp == 2'(newp + 2'd1)) return 2;
        if (oldp == 2'(newp - 2'd1)) return 1;
        return 0;
    endfunction

    task automatic cycle(input logic we, input logic [7:0] d, input logic s, input logic w);
        int dir;
        logic evt;
        @(negedge clk);
        wr_en = we; wr_data = d; sync_det = s; wprot = w;
        dir = we ? f_dir(m_port[1:0], d[1:0]) : 0;
        evt = we && (d[3] != m_port[3]);
        if (we) begin
            m_port = d;
            m_port[4] = 1'b0;
        end
        if (dir == 1) m_track++;
        if (dir == 2) m_track--;
        @(posedge clk);
        #2;
        if (step_in) d_track++;
        if (step_out) d_track--;
        check(dir == 1 ? "R4 step_in" : "R5/R6 step_in", 32'(step_in), 32'(dir == 1));
        check(dir == 2 ? "R3 step_out" : "R5/R6 step_out", 32'(step_out), 32'(dir == 2));
        check("R7 led_on", 32'(led_on), 32'(m_port[3]));
        check("R8 led_evt", 32'(led_evt), 32'(evt));
        check(we ? "R2 rd_data" : "R10 rd_data", 32'(rd_data), 32'(f_read(m_port, s, w)));
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset step_in", 32'(step_in), 0);
        check("R1 reset step_out", 32'(step_out), 0);
        check("R1 reset led", 32'({led_on, led_evt}), 0);
        check("R1 reset rd_data", 32'(rd_data), 32'h80);
        @(negedge clk);
        rst_n = 1'b1;
        cycle(1'b0, 8'hff, 1'b0, 1'b0);
        check("R1 after release", 32'(rd_data), 32'h80);
        // R4: walk phases forward 0->1->2->3->0
        for (int i = 1; i <= 4; i++) cycle(1'b1, 8'(i & 3), 1'b1, 1'b0);
        // R3: walk backward
        for (int i = 3; i >= 0; i--) cycle(1'b1, 8'(i), 1'b0, 1'b1);
        // R5: opposite and same phase
        cycle(1'b1, 8'h02, 1'b0, 1'b0);
        cycle(1'b1, 8'h00, 1'b0, 1'b0);
        cycle(1'b1, 8'h00, 1'b0, 1'b0);
        cycle(1'b1, 8'h03, 1'b0, 1'b0);
        cycle(1'b1, 8'h01, 1'b0, 1'b0);
        // R2: bit 4 cleared, R8: LED bit toggles
        cycle(1'b1, 8'hff, 1'b0, 1'b0);
        check("R2 bit4 cleared", 32'(rd_data[4]), 0);
        cycle(1'b1, 8'hf7, 1'b1, 1'b0);
        cycle(1'b1, 8'hf7, 1'b1, 1'b1);
        // R9: inputs alone change the read value
        cycle(1'b0, 8'h00, 1'b1, 1'b1);
        check("R9 sync bit", 32'(rd_data[7]), 0);
        cycle(1'b0, 8'h00, 1'b0, 1'b0);
        check("R9 sync bit idle", 32'(rd_data[7]), 1);
        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            cycle(r[0] | r[1], r[15:8], r[2], r[3]);
        end
        check("R3/R4 track", 32'(d_track), 32'(m_track));
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule